// File: doc/BRIEF.md
# Triple Interval Timer

The block holds three identical count-up timer channels behind one synchronous register port. Each channel picks one of two tick inputs, optionally divides it by a power of two, and advances its counter on the resulting step. It can free-run up to the counter maximum or wrap at a programmed interval. Interval wraps and overflows latch status bits. Each channel raises its own level interrupt when an enabled status bit is pending.

Software sets the divider and the tick source, loads an interval, enables the interrupts it wants, and then clears the channel's stop bit. The live count can be read back at any time. Reading a channel's status returns the pending events and clears them. The counter width is a parameter (16 or 32). The tick inputs are single-cycle strobes that are already synchronous to `clk`.

Top module: `triple_interval_timer`

## Requirements
- R1: After reset, every channel's counter control reads 0x1 (stopped). Clock control, count, interval, status and enable all read 0, and every interrupt output is low.
- R2: Register groups are at byte offsets 0x00 (clock control), 0x0C (counter control), 0x18 (count, read-only), 0x24 (interval), 0x54 (status, read-only) and 0x60 (enable). Channels 0, 1 and 2 sit at +0, +4 and +8 within each group. Writes to read-only or unmapped addresses change nothing, and reads of unmapped addresses return 0.
- R3: In free-run mode (counter control bit 1 = 0) the count rises by one per step and wraps from its maximum (0xFFFF at 16 bits) to 0. The wrap sets status bit 4.
- R4: With clock control bit 0 set, one step occurs every 2^(N+1) selected ticks, where N is clock control bits 4:1. With bit 0 clear, every selected tick is a step.
- R5: Clock control bit 5 selects the tick source: 0 picks `tick_a_i` and 1 picks `tick_b_i`.
- R6: While counter control bit 0 is set, the count and the divider hold. Clearing the bit resumes counting from the held value.
- R7: Writing counter control with bit 4 set clears the count and the divider in that cycle. Bit 4 is not stored and reads back as 0.
- R8: In interval mode (counter control bit 1 = 1), a step taken when the count equals the interval register wraps the count to 0 and sets status bit 0.
- R9: Reading a status register returns its pending bits and clears them. An event that occurs in the same cycle as the read stays pending.
- R10: A channel's interrupt is high exactly when status bit 0 and enable bit 0 are both set, or status bit 4 and enable bit 4 are both set. With enables at 0 the interrupt stays low and counting continues.
- R11: Rewriting clock control while running changes the divide ratio without clearing the count.
- R12: Read data appears on `reg_rdata_o` one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a_i | input | 1 | Tick source A strobe |
| tick_b_i | input | 1 | Tick source B strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 3 | Per-channel level interrupt |

## Verification
A wrong divider phase, or a count that is off by one, shows up in the next count read-back. It also shows as a shift in the cycle where status and interrupt change. The bench model predicts both every clock, so the first cycle that disagrees is reported. A status clear that is lost or misordered shows on `irq_o` in the cycle after the read. A stop or restart that is decoded wrongly shows as a count that moves, or fails to move, between two reads a few cycles apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        GRP_CLK,
        GRP_CNT,
        GRP_VAL,
        GRP_IVL,
        GRP_STS,
        GRP_IEN
    } grp_e;

    localparam int CFG_PSC_EN  = 0;
    localparam int CFG_SRC_SEL = 5;
    localparam int CTL_STOP    = 0;
    localparam int CTL_IVL     = 1;
    localparam int CTL_RESTART = 4;
    localparam int EV_IVL      = 0;
    localparam int EV_OVF      = 4;
    localparam int CH_STRIDE   = 4;
    localparam logic [5:0] IRQ_MASK = 6'b010001;

    function automatic logic [7:0] grp_off(grp_e g);
        case (g)
            GRP_CLK: return 8'h00;
            GRP_CNT: return 8'h0C;
            GRP_VAL: return 8'h18;
            GRP_IVL: return 8'h24;
            GRP_STS: return 8'h54;
            GRP_IEN: return 8'h60;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic             psc_en,
    input  logic [PSC_W-1:0] psc_n,
    output logic             step
);
    localparam int DIV_W = 1 << PSC_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic [PSC_W:0] shift_amt;
    logic [DIV_W:0] limit;

    always_comb begin
        st_d      = st_q;
        step      = 1'b0;
        shift_amt = {1'b0, psc_n} + (PSC_W+1)'(1);
        limit     = ((DIV_W+1)'(1) << shift_amt) - (DIV_W+1)'(1);
        if (restart) begin
            st_d.div = '0;
        end else if (run && tick) begin
            if (!psc_en) begin
                st_d.div = '0;
                step     = 1'b1;
            end else if ({1'b0, st_q.div} >= limit) begin
                st_d.div = '0;
                step     = 1'b1;
            end else begin
                st_d.div = st_q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             wr_cfg,
    input  logic             wr_ctl,
    input  logic             wr_ivl,
    input  logic             wr_ien,
    input  logic             rd_sts,
    input  logic [31:0]      wdata,
    output logic [5:0]       cfg,
    output logic             stop,
    output logic             ivl_mode,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] interval,
    output logic [5:0]       status,
    output logic [5:0]       ien,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [5:0]       cfg;
        logic             stop;
        logic             ivl_mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ivl;
        logic [5:0]       sts;
        logic [5:0]       ien;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic sel_tick, restart, step, ev_ivl, ev_ovf;

    assign sel_tick = st_q.cfg[CFG_SRC_SEL] ? tick_b : tick_a;
    assign restart  = wr_ctl & wdata[CTL_RESTART];

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sel_tick),
        .run     (~st_q.stop),
        .restart (restart),
        .psc_en  (st_q.cfg[CFG_PSC_EN]),
        .psc_n   (st_q.cfg[PSC_W:1]),
        .step    (step)
    );

    always_comb begin
        st_d   = st_q;
        ev_ivl = 1'b0;
        ev_ovf = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.ivl_mode && (st_q.cnt == st_q.ivl)) begin
                st_d.cnt = '0;
                ev_ivl   = 1'b1;
            end else if (st_q.cnt == CNT_MAX) begin
                st_d.cnt = '0;
                ev_ovf   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (rd_sts) st_d.sts = '0;
        if (ev_ivl) st_d.sts[EV_IVL] = 1'b1;
        if (ev_ovf) st_d.sts[EV_OVF] = 1'b1;
        if (wr_cfg) st_d.cfg = wdata[5:0];
        if (wr_ctl) begin
            st_d.stop     = wdata[CTL_STOP];
            st_d.ivl_mode = wdata[CTL_IVL];
        end
        if (wr_ivl) st_d.ivl = wdata[CNT_W-1:0];
        if (wr_ien) st_d.ien = wdata[5:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stop <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign stop     = st_q.stop;
    assign ivl_mode = st_q.ivl_mode;
    assign count    = st_q.cnt;
    assign interval = st_q.ivl;
    assign status   = st_q.sts;
    assign ien      = st_q.ien;
    assign irq      = |(st_q.sts & st_q.ien & IRQ_MASK);
endmodule

// File: rtl/triple_interval_timer.sv
module triple_interval_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a_i,
    input  logic              tick_b_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [2:0]        irq_o
);
    localparam int NCH = 3;

    typedef struct packed {
        logic [31:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [NCH-1:0]            hit_cfg, hit_ctl, hit_val, hit_ivl, hit_sts, hit_ien;
    logic [NCH-1:0][5:0]       cfg_w, sts_w, ien_w;
    logic [NCH-1:0]            stop_w, mode_w;
    logic [NCH-1:0][CNT_W-1:0] cnt_w, ivl_w;

    function automatic logic at(logic [ADDR_W-1:0] a, grp_e g, int c);
        return a == (ADDR_W'(grp_off(g)) + ADDR_W'(CH_STRIDE * c));
    endfunction

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            hit_cfg[c] = at(reg_addr_i, GRP_CLK, c);
            hit_ctl[c] = at(reg_addr_i, GRP_CNT, c);
            hit_val[c] = at(reg_addr_i, GRP_VAL, c);
            hit_ivl[c] = at(reg_addr_i, GRP_IVL, c);
            hit_sts[c] = at(reg_addr_i, GRP_STS, c);
            hit_ien[c] = at(reg_addr_i, GRP_IEN, c);
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_a   (tick_a_i),
            .tick_b   (tick_b_i),
            .wr_cfg   (reg_wr_i & hit_cfg[c]),
            .wr_ctl   (reg_wr_i & hit_ctl[c]),
            .wr_ivl   (reg_wr_i & hit_ivl[c]),
            .wr_ien   (reg_wr_i & hit_ien[c]),
            .rd_sts   (reg_rd_i & hit_sts[c]),
            .wdata    (reg_wdata_i),
            .cfg      (cfg_w[c]),
            .stop     (stop_w[c]),
            .ivl_mode (mode_w[c]),
            .count    (cnt_w[c]),
            .interval (ivl_w[c]),
            .status   (sts_w[c]),
            .ien      (ien_w[c]),
            .irq      (irq_o[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_rd_i) begin
            st_d.rdata = '0;
            for (int c = 0; c < NCH; c++) begin
                if (hit_cfg[c]) st_d.rdata = 32'(cfg_w[c]);
                if (hit_ctl[c]) st_d.rdata = 32'({mode_w[c], stop_w[c]});
                if (hit_val[c]) st_d.rdata = 32'(cnt_w[c]);
                if (hit_ivl[c]) st_d.rdata = 32'(ivl_w[c]);
                if (hit_sts[c]) st_d.rdata = 32'(sts_w[c] & IRQ_MASK);
                if (hit_ien[c]) st_d.rdata = 32'(ien_w[c]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata_o = st_q.rdata;
endmodule

// File: rtl/triple_interval_timer_chk.sv
module triple_interval_timer_chk #(
    parameter int NCH    = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_wr_i,
    input logic [ADDR_W-1:0]         reg_addr_i,
    input logic                      restart_bit,
    input logic [NCH-1:0][CNT_W-1:0] cnt_i,
    input logic [NCH-1:0]            stop_i,
    input logic [NCH-1:0][5:0]       sts_i,
    input logic [NCH-1:0][5:0]       ien_i,
    input logic [NCH-1:0]            irq_i
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic restart;
        assign restart = reg_wr_i && restart_bit &&
                         (reg_addr_i == ADDR_W'(8'h0C + 4 * c));

        // R3: count moves by at most one step, or wraps to zero
        a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt_i[c] == $past(cnt_i[c]) ||
                      cnt_i[c] == CNT_W'($past(cnt_i[c]) + CNT_W'(1)) ||
                      cnt_i[c] == '0));

        // R3: a new overflow event coincides with a zero count
        a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_i[c][4]) |-> cnt_i[c] == '0);

        // R6: a stopped channel holds its count
        a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_i[c] && !restart) |=> $stable(cnt_i[c]));

        // R7: restart clears the count on the next edge
        a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> cnt_i[c] == '0);

        // R8: a new interval event coincides with a zero count
        a_r8_ivl_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_i[c][0]) |-> cnt_i[c] == '0);

        // R10: no interrupt without an enable
        a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!ien_i[c][0] && !ien_i[c][4]) |-> !irq_i[c]);
    end
endmodule

bind triple_interval_timer triple_interval_timer_chk #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .restart_bit (reg_wdata_i[4]),
    .cnt_i       (cnt_w),
    .stop_i      (stop_w),
    .sts_i       (sts_w),
    .ien_i       (ien_w),
    .irq_i       (irq_o)
);

// File: tb/triple_interval_timer_tb_top.sv
`timescale 1ns/1ps
module triple_interval_timer_tb_top;
    localparam int CNT_W = 16;
    localparam int NCH   = 3;
    localparam longint MAXV = (64'd1 << CNT_W) - 1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        tick_a = 1'b0, tick_b = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  irq;

    always #4 clk = ~clk;

    triple_interval_timer #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_a_i(tick_a), .tick_b_i(tick_b),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit started = 0, done = 0;

    int     m_cfg[NCH], m_sts[NCH], m_ien[NCH];
    bit     m_stop[NCH], m_mode[NCH];
    longint m_cnt[NCH], m_ivl[NCH], m_div[NCH];
    logic [31:0] m_rdata;

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(logic [7:0] a);
        for (int c = 0; c < NCH; c++) begin
            if (a == 8'(8'h00 + 4*c)) return 32'(m_cfg[c]);
            if (a == 8'(8'h0C + 4*c)) return {30'd0, m_mode[c], m_stop[c]};
            if (a == 8'(8'h18 + 4*c)) return 32'(m_cnt[c]);
            if (a == 8'(8'h24 + 4*c)) return 32'(m_ivl[c]);
            if (a == 8'(8'h54 + 4*c)) return 32'(m_sts[c]);
            if (a == 8'(8'h60 + 4*c)) return 32'(m_ien[c]);
        end
        return 32'd0;
    endfunction

    function automatic logic [2:0] m_irq();
        logic [2:0] r;
        for (int c = 0; c < NCH; c++) r[c] = ((m_sts[c] & m_ien[c] & 'h11) != 0);
        return r;
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_cfg[c] = 0; m_stop[c] = 1; m_mode[c] = 0; m_cnt[c] = 0;
                m_ivl[c] = 0; m_sts[c] = 0; m_ien[c] = 0; m_div[c] = 0;
            end
            m_rdata = '0;
        end else begin
            if (reg_rd) m_rdata = m_read(reg_addr) & 32'hFFFF_FFFF;
            for (int c = 0; c < NCH; c++) begin
                bit tk, stp, ei, eo;
                tk = ((m_cfg[c] >> 5) & 1) ? tick_b : tick_a;
                stp = 0; ei = 0; eo = 0;
                if (reg_wr && reg_addr == 8'(8'h0C + 4*c) && reg_wdata[4]) begin
                    m_cnt[c] = 0; m_div[c] = 0;
                end else begin
                    if (!m_stop[c] && tk) begin
                        if ((m_cfg[c] & 1) == 0) begin
                            stp = 1; m_div[c] = 0;
                        end else if (m_div[c] >= (64'd1 << (((m_cfg[c] >> 1) & 15) + 1)) - 1) begin
                            stp = 1; m_div[c] = 0;
                        end else m_div[c]++;
                    end
                    if (stp) begin
                        if (m_mode[c] && m_cnt[c] == m_ivl[c]) begin m_cnt[c] = 0; ei = 1; end
                        else if (m_cnt[c] == MAXV) begin m_cnt[c] = 0; eo = 1; end
                        else m_cnt[c]++;
                    end
                end
                if (reg_rd && reg_addr == 8'(8'h54 + 4*c)) m_sts[c] = 0;
                if (ei) m_sts[c] |= 'h01;
                if (eo) m_sts[c] |= 'h10;
                if (reg_wr) begin
                    if (reg_addr == 8'(8'h00 + 4*c)) m_cfg[c] = reg_wdata & 'h3F;
                    if (reg_addr == 8'(8'h0C + 4*c)) begin
                        m_stop[c] = reg_wdata[0]; m_mode[c] = reg_wdata[1];
                    end
                    if (reg_addr == 8'(8'h24 + 4*c)) m_ivl[c] = reg_wdata & MAXV;
                    if (reg_addr == 8'(8'h60 + 4*c)) m_ien[c] = reg_wdata & 'h3F;
                end
            end
        end
    end

    // tick stimulus
    initial forever begin
        @(negedge clk);
        cyc++;
        tick_a = (cyc % 7 != 0);
        tick_b = (cyc % 3 == 0);
    end

    // per-clock comparison against the model (R12 covers read timing)
    initial forever begin
        @(negedge clk);
        if (started && !done) begin
            chk(cur_req, "rdata", reg_rdata, m_rdata);
            chk(cur_req, "irq", irq, m_irq());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 190000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(negedge clk);
        started = 1;
        rst_n = 1;
        @(negedge clk);

        cur_req = "R1";
        chk("R1", "irq after reset", irq, 0);
        rd(8'h0C); chk("R1", "stop after reset", reg_rdata, 1);
        rd(8'h00); rd(8'h18); rd(8'h24); rd(8'h54); rd(8'h64);

        cur_req = "R2";
        wr(8'h24, 32'h1111); wr(8'h28, 32'h2222); wr(8'h2C, 32'h3333);
        rd(8'h28); chk("R2", "interval ch1", reg_rdata, 32'h2222);
        wr(8'h1C, 32'hABCD); rd(8'h1C); chk("R2", "read-only count", reg_rdata, 0);
        wr(8'h99, 32'hFFFF); rd(8'h99); chk("R2", "unmapped", reg_rdata, 0);

        cur_req = "R3";
        wr(8'h60, 32'h10);
        wr(8'h0C, 32'h0);
        idle(76600);
        rd(8'h54); chk("R3", "overflow flag", reg_rdata & 32'h10, 32'h10);
        wr(8'h0C, 32'h1);
        cur_req = "R9";
        rd(8'h54); chk("R9", "status after clear", reg_rdata, 0);
        chk("R9", "irq0 after clear", irq[0], 0);

        cur_req = "R8";
        wr(8'h28, 32'd5); wr(8'h64, 32'h1); wr(8'h10, 32'h2);
        idle(30);
        rd(8'h58); chk("R8", "interval flag", reg_rdata & 1, 1);
        rd(8'h1C); idle(9); rd(8'h58); rd(8'h58);

        cur_req = "R10";
        wr(8'h64, 32'h0); idle(20);
        chk("R10", "irq1 masked", irq[1], 0);
        rd(8'h1C);

        cur_req = "R6";
        wr(8'h10, 32'h3); rd(8'h1C); held = reg_rdata;
        idle(10); rd(8'h1C); chk("R6", "held count", reg_rdata, held);
        wr(8'h10, 32'h2); idle(6); rd(8'h1C);

        cur_req = "R7";
        wr(8'h10, 32'h13); rd(8'h1C); chk("R7", "count cleared", reg_rdata, 0);
        rd(8'h10); chk("R7", "restart self-clear", reg_rdata, 3);
        wr(8'h10, 32'h12); idle(12); rd(8'h1C);

        cur_req = "R4";
        wr(8'h08, 32'h03); wr(8'h14, 32'h0); idle(40); rd(8'h20);

        cur_req = "R11";
        wr(8'h08, 32'h07); rd(8'h20); idle(100); rd(8'h20);
        wr(8'h08, 32'h01); idle(10); rd(8'h20);

        cur_req = "R5";
        wr(8'h08, 32'h20); idle(30); rd(8'h20);
        wr(8'h08, 32'h21); idle(30); rd(8'h20);

        cur_req = "R12";
        rd(8'h2C); idle(3); chk("R12", "rdata holds", reg_rdata, 32'h3333);

        idle(2);
        finish_run();
    end
endmodule